// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is a SIMD datapath slice for a vector unit. It takes two packed byte vectors and a packed vector of 32-bit accumulators. In every 32-bit lane it multiplies four bytes of the first operand, treated as unsigned, by the four matching bytes of the second operand, treated as signed. It adds up the four products and adds that sum to the lane's accumulator. The result wraps to 32 bits. The block does not saturate and keeps no flags.

Two controls shape each operation. A width select chooses between 128-bit operation (four lanes) and 64-bit operation (two lanes, with the upper half of the result forced to zero). An indexed mode picks one 32-bit group of the second operand, chosen by a two-bit group number, and feeds it to every lane in place of that lane's own group.

Operations enter through a valid/ready handshake, one per cycle. They pass through two register stages, and a stalled output freezes the whole pipe.

Top module: `mixed_dot_acc`

## Requirements
- R1: Result lane e (bits 32e+31:32e) equals acc_in lane e plus the sum of the four products of byte 4e+b of src_u and byte 4e+b of the selected second operand, for b = 0..3 (byte k is bits 8k+7:8k).
- R2: Bytes of src_u are read as unsigned values 0..255, and bytes of src_s are read as two's-complement values -128..127. The four-product sum always stays within -130560..129540.
- R3: Each lane result is taken modulo 2^32, so an accumulator overflow wraps and never saturates.
- R4: With wide = 1, all four lanes are computed independently of one another.
- R5: With wide = 0, only lanes 0 and 1 are computed, and result bits 127:64 are zero whatever the upper input bits hold.
- R6: With indexed = 1, group grp_sel of src_s (bits 32g+31:32g) is used for every lane. With indexed = 0, grp_sel has no effect.
- R7: An operation accepted at clock edge k appears on result with out_valid = 1 after edge k+1. It is not visible after edge k.
- R8: While out_valid = 1 and out_ready = 0, out_valid and result hold unchanged and no stage advances.
- R9: in_ready is 1 whenever out_valid = 0 or out_ready = 1. This lets the block accept one operation per cycle without gaps.
- R10: A synchronous reset clears every stage's valid flag, so out_valid = 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| wide | input | 1 | 1 = 128-bit (four lanes), 0 = 64-bit (two lanes) |
| indexed | input | 1 | 1 = broadcast one group of src_s to every lane |
| grp_sel | input | 2 | Group number used in indexed mode |
| src_u | input | 128 | Unsigned byte operand |
| src_s | input | 128 | Signed byte operand |
| acc_in | input | 128 | Four 32-bit accumulators |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes result |
| result | output | 128 | Four 32-bit lane results |

## Verification
Two things can happen in the same cycle: a held output under backpressure and a new operation offered at the input. The bench keeps out_ready low while a second and then a third operation arrive. It checks that in_ready drops, that the held result stays bit-exact, and that the queued operations come out in order once out_ready rises. A second case is a drain and an accept on one edge. The bench issues operations back to back with out_ready high, then checks that each result lands exactly one edge after the one before it and matches the reference model.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
    localparam int LANES   = 4;
    localparam int BPL     = 4;
    localparam int BYTE_W  = 8;
    localparam int ACC_W   = 32;
    localparam int VEC_W   = LANES * BPL * BYTE_W;
    localparam int PROD_W  = 2 * BYTE_W + 1;
    localparam int SUM_W   = PROD_W + $clog2(BPL);
    localparam int IDX_W   = $clog2(LANES);
    localparam int SUM_MIN = -(BPL * ((1 << BYTE_W) - 1) * (1 << (BYTE_W - 1)));
    localparam int SUM_MAX = BPL * ((1 << BYTE_W) - 1) * ((1 << (BYTE_W - 1)) - 1);

    typedef struct packed {
        logic                   vld;
        logic                   wide;
        logic [LANES*ACC_W-1:0] acc;
        logic [LANES*SUM_W-1:0] sums;
    } stage1_t;

    typedef struct packed {
        logic                   vld;
        logic [LANES*ACC_W-1:0] res;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;
endpackage

// File: rtl/mdp_lane_sum.sv
module mdp_lane_sum #(
    parameter int BPL    = 4,
    parameter int BYTE_W = 8,
    parameter int SUM_W  = 19
) (
    input  logic [BPL*BYTE_W-1:0] u_bytes,
    input  logic [BPL*BYTE_W-1:0] s_bytes,
    output logic signed [SUM_W-1:0] sum
);
    localparam int PROD_W = 2 * BYTE_W + 1;

    logic signed [PROD_W-1:0] uext;
    logic signed [PROD_W-1:0] sext;
    logic signed [PROD_W-1:0] prod;

    // zero-extend the unsigned byte, sign-extend the signed one, then multiply
    always_comb begin
        sum  = '0;
        uext = '0;
        sext = '0;
        prod = '0;
        for (int b = 0; b < BPL; b++) begin
            uext = PROD_W'(u_bytes[b*BYTE_W +: BYTE_W]);
            sext = PROD_W'($signed(s_bytes[b*BYTE_W +: BYTE_W]));
            prod = uext * sext;
            sum  = sum + SUM_W'(prod);
        end
    end
endmodule

// File: rtl/mdp_grp_sel.sv
module mdp_grp_sel #(
    parameter int LANES = 4,
    parameter int GRP_W = 32,
    parameter int IDX_W = 2
) (
    input  logic [LANES*GRP_W-1:0] src,
    input  logic                   indexed,
    input  logic [IDX_W-1:0]       idx,
    output logic [LANES*GRP_W-1:0] grp
);
    logic [GRP_W-1:0] bcast;
    assign bcast = src[idx*GRP_W +: GRP_W];

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        assign grp[e*GRP_W +: GRP_W] = indexed ? bcast : src[e*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/mixed_dot_acc.sv
module mixed_dot_acc
    import mdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              wide,
    input  logic              indexed,
    input  logic [IDX_W-1:0]  grp_sel,
    input  logic [VEC_W-1:0]  src_u,
    input  logic [VEC_W-1:0]  src_s,
    input  logic [VEC_W-1:0]  acc_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  result
);
    localparam int GRP_W  = BPL * BYTE_W;
    localparam int HALF_L = LANES / 2;

    pipe_t pipe_d, pipe_q;
    logic  adv;
    logic [VEC_W-1:0]       s_grp;
    logic [LANES*SUM_W-1:0] lane_sums;

    mdp_grp_sel #(.LANES(LANES), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_sel (
        .src     (src_s),
        .indexed (indexed),
        .idx     (grp_sel),
        .grp     (s_grp)
    );

    for (genvar e = 0; e < LANES; e++) begin : g_sum
        mdp_lane_sum #(.BPL(BPL), .BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_sum (
            .u_bytes (src_u[e*GRP_W +: GRP_W]),
            .s_bytes (s_grp[e*GRP_W +: GRP_W]),
            .sum     (lane_sums[e*SUM_W +: SUM_W])
        );
    end

    always_comb begin
        adv    = !pipe_q.s2.vld || out_ready;
        pipe_d = pipe_q;
        if (adv) begin
            pipe_d.s1.vld  = in_valid;
            pipe_d.s1.wide = wide;
            pipe_d.s1.acc  = acc_in;
            pipe_d.s1.sums = lane_sums;
            pipe_d.s2.vld  = pipe_q.s1.vld;
            for (int e = 0; e < LANES; e++) begin
                if (pipe_q.s1.wide || e < HALF_L) begin
                    pipe_d.s2.res[e*ACC_W +: ACC_W] = pipe_q.s1.acc[e*ACC_W +: ACC_W]
                        + ACC_W'($signed(pipe_q.s1.sums[e*SUM_W +: SUM_W]));
                end else begin
                    pipe_d.s2.res[e*ACC_W +: ACC_W] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign in_ready  = adv;
    assign out_valid = pipe_q.s2.vld;
    assign result    = pipe_q.s2.res;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(result)); // R8
    AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R9
    AST_ISSUE_FLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> pipe_q.s1.vld); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !out_valid); // R10

    for (genvar e = 0; e < LANES; e++) begin : g_chk
        AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst)
            pipe_q.s1.vld |-> ($signed(pipe_q.s1.sums[e*SUM_W +: SUM_W]) >= SUM_MIN
                            && $signed(pipe_q.s1.sums[e*SUM_W +: SUM_W]) <= SUM_MAX)); // R2
    end
endmodule

// File: tb/mixed_dot_acc_bench.sv
module mixed_dot_acc_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic         wide;
        logic         ix;
        logic [1:0]   g;
        logic [127:0] u;
        logic [127:0] s;
        logic [127:0] acc;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 2'd0, 128'h0102030405060708090A0B0C0D0E0F10,
          128'h01FF02FE03FD04FC05FB06FA07F908F8, 128'h00000010FFFFFFF0800000007FFFFFF0},
        '{1'b1, 1'b0, 2'd1, {128{1'b1}},
          128'h7F7F7F7F8080808001010101FFFFFFFF, 128'h0},
        '{1'b0, 1'b0, 2'd0, {16{8'h55}},
          128'h123456789ABCDEF00F1E2D3C4B5A6978, 128'h11111111222222223333333344444444},
        '{1'b1, 1'b1, 2'd2, 128'hDEADBEEFCAFEBABE0123456789ABCDEF,
          128'h0000000080FF7F010000000000000000, 128'h00000005000000060000000700000008},
        '{1'b0, 1'b1, 2'd3, 128'hFFEEDDCCBBAA99887766554433221100,
          128'hF0E1D2C3000000000000000000000000, 128'hAAAAAAAABBBBBBBBCCCCCCCCDDDDDDDD},
        '{1'b1, 1'b0, 2'd3, 128'h0F0F0F0FF0F0F0F0A5A5A5A55A5A5A5A,
          128'h01020304FFFEFDFC7F80017F80807F7F, 128'h0000000100000002FFFFFFFF80000000}
    };

    logic         clk = 0;
    logic         rst = 1;
    logic         in_valid = 0;
    logic         in_ready;
    logic         wide = 1;
    logic         indexed = 0;
    logic [1:0]   grp_sel = 0;
    logic [127:0] src_u = 0;
    logic [127:0] src_s = 0;
    logic [127:0] acc_in = 0;
    logic         out_valid;
    logic         out_ready = 1;
    logic [127:0] result;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixed_dot_acc u_mixed_dot_acc (
        .clk, .rst, .in_valid, .in_ready, .wide, .indexed, .grp_sel,
        .src_u, .src_s, .acc_in, .out_valid, .out_ready, .result
    );

    function automatic logic [127:0] model(vec_t v);
        logic [127:0] r = '0;
        for (int e = 0; e < (v.wide ? 4 : 2); e++) begin
            int sum = int'(v.acc[e*32 +: 32]);
            int gi  = v.ix ? int'(v.g) : e;
            for (int b = 0; b < 4; b++) begin
                logic [7:0] ub = v.u[(4*e+b)*8 +: 8];
                logic [7:0] sb = v.s[(4*gi+b)*8 +: 8];
                sum = sum + int'({24'd0, ub}) * int'({{24{sb[7]}}, sb});
            end
            r[e*32 +: 32] = sum;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        wide = v.wide; indexed = v.ix; grp_sel = v.g;
        src_u = v.u; src_s = v.s; acc_in = v.acc;
    endtask

    // issue one op at a negedge, confirm latency, return after result checked
    task automatic run_op(string tag, vec_t v);
        @(negedge clk);
        drive(v); in_valid = 1; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check({tag, " R7 not yet valid"}, 128'(out_valid), 128'(0));
        @(negedge clk);
        check({tag, " R7 valid"}, 128'(out_valid), 128'(1));
        check(tag, result, model(v));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        vec_t a, b, c, v;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", 128'(out_valid), 128'(0));
        rst = 0;
        @(negedge clk);
        check("R9 idle in_ready", 128'(in_ready), 128'(1));

        // table walk: R1 R4 R5 R6
        for (int i = 0; i < NV; i++) run_op("R1 R4 R5 R6 table", TBL[i]);

        // R2 extreme: all 255 times all -128
        v = '{1'b1, 1'b0, 2'd0, {128{1'b1}}, {16{8'h80}}, 128'h0};
        run_op("R2 extreme", v);
        check("R2 extreme lane0", 128'(result[31:0]), 128'(32'hFFFE0200));

        // R3 wraparound
        v = '{1'b1, 1'b0, 2'd0, {16{8'h01}}, {16{8'h01}},
              {32'hFFFFFFFE, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFC}};
        run_op("R3 wrap", v);
        check("R3 wrap lanes", result,
              {32'h00000002, 32'h80000003, 32'h80000004, 32'h00000000});

        // R6 every indexed group, 128-bit
        for (int g = 0; g < 4; g++) begin
            v = '{1'b1, 1'b1, 2'(g), 128'h0102030405060708090A0B0C0D0E0F10,
                  128'h7F80FF01027EFD03117722EE33DD44CC, 128'h0};
            run_op("R6 index", v);
        end

        // R5 narrow: upper input garbage must not reach the result
        v = '{1'b0, 1'b0, 2'd0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}};
        run_op("R5 narrow", v);
        check("R5 upper zero", 128'(result[127:64]), 128'(0));

        // R6 group select ignored in lane-wise mode
        v = TBL[0]; v.g = 2'd2;
        run_op("R6 grp ignored", v);
        check("R6 grp ignored vs g0", result, model(TBL[0]));

        // R8/R9 stall with new input offered in same cycles
        a = TBL[1]; b = TBL[3]; c = TBL[5];
        @(negedge clk);
        drive(a); in_valid = 1; out_ready = 0;
        @(negedge clk);
        drive(b);
        @(negedge clk);
        drive(c);
        check("R9 ready low in stall", 128'(in_ready), 128'(0));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 hold valid", 128'(out_valid), 128'(1));
            check("R8 hold result", result, model(a));
            check("R9 ready low", 128'(in_ready), 128'(0));
        end
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check("R8 drain b", result, model(b));
        @(negedge clk);
        check("R7 back-to-back c", result, model(c));
        check("R7 c valid", 128'(out_valid), 128'(1));
        @(negedge clk);
        check("R7 empty after drain", 128'(out_valid), 128'(0));

        // R10 reset with an op in flight
        @(negedge clk);
        drive(TBL[2]); in_valid = 1;
        @(negedge clk);
        in_valid = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        check("R10 flush", 128'(out_valid), 128'(0));
        @(negedge clk);
        check("R10 flush later", 128'(out_valid), 128'(0));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule